// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns one protection entry's settings into an inclusive byte-address window. It takes three inputs: a two-bit match mode, the entry's own address register and the address register of the entry just below it. Both registers hold a byte address divided by four. From these it produces a start and an end byte address. Both outputs are XLEN+2 bits wide, so every shifted register value fits without loss. A range comparator downstream tests access addresses against that window.

The block has no clock and no state. One copy is placed per entry. The `ENTRY_IDX` parameter marks the lowest entry, which has no neighbour below it. For that entry the previous address is taken as zero and the neighbour input is not used. All arithmetic wraps modulo 2^(XLEN+2).

Top module: `region_bounds_decoder`

## Requirements
- R1: With mode 0 (disabled), start is 0 and end has all XLEN+2 bits set, whatever the address inputs hold.
- R2: With mode 1 (top-of-range), when the window is not inverted, start is the previous register shifted left by 2 and end is the own register shifted left by 2, minus 1.
- R3: With mode 1, when the computed start is greater than the computed end (this includes equal registers), both start and end are 0.
- R4: For the entry with `ENTRY_IDX` = 0, the previous-register input has no effect, and the previous address is taken as 0.
- R5: With mode 2 (four-byte cell), start is the own register shifted left by 2 and end is start plus 3.
- R6: With mode 3 (power-of-two region), let t = (own register << 2) | 3. Then start = t & (t+1) and end = t | (t+1). A register whose k low bits are set, with the next bit clear, yields a window of 2^(k+3) bytes that is aligned to its own size.
- R7: With mode 3 and an all-ones own register, the window covers the whole space: start is 0 and end is all ones.
- R8: With mode 1 and a zero own register, the end wraps to all ones, so the window runs from the previous address to the top of the space.
- R9: The outputs follow the inputs combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Match mode: 0 disabled, 1 top-of-range, 2 four-byte, 3 power-of-two |
| addr_cur_i | input | XLEN | This entry's address register (byte address divided by 4) |
| addr_prev_i | input | XLEN | Address register of the entry below (not used when ENTRY_IDX is 0) |
| start_o | output | XLEN+2 | Inclusive first byte address of the window |
| end_o | output | XLEN+2 | Inclusive last byte address of the window |

## Verification
The bench builds two copies of the block. The first uses XLEN=32 and ENTRY_IDX=3. It has a live neighbour input, so it exercises the top-of-range boundaries (inverted, equal and zero-register wrap), the four-byte cell at the top of the space and a sweep of power-of-two sizes over a high base. The second uses XLEN=8 and ENTRY_IDX=0. There, 10-bit outputs make the full-space cases small, and a deliberately non-zero neighbour value shows that the lowest entry ignores it.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    typedef enum logic [1:0] {
        RGN_OFF   = 2'd0,
        RGN_TOR   = 2'd1,
        RGN_NA4   = 2'd2,
        RGN_NAPOT = 2'd3
    } region_mode_e;

endpackage

// File: rtl/rbd_tor_decode.sv
module rbd_tor_decode #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] prev_i,
    input  logic [XLEN-1:0] cur_i,
    output logic [XLEN+1:0] lo_o,
    output logic [XLEN+1:0] hi_o
);
    localparam int W = XLEN + 2;

    logic [W-1:0] lo_raw;
    logic [W-1:0] hi_raw;
    logic         inverted;

    always_comb begin
        lo_raw   = {prev_i, 2'b00};
        hi_raw   = {cur_i, 2'b00} - W'(1);
        inverted = lo_raw > hi_raw;
        if (inverted) begin
            lo_o = '0;
            hi_o = '0;
        end else begin
            lo_o = lo_raw;
            hi_o = hi_raw;
        end
        AST_TOR_ORDER: assert (lo_o <= hi_o); // R3
        AST_TOR_LO_SRC: assert (lo_o == '0 || lo_o == {prev_i, 2'b00}); // R2
    end

endmodule

// File: rtl/rbd_na4_decode.sv
module rbd_na4_decode #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_i,
    output logic [XLEN+1:0] lo_o,
    output logic [XLEN+1:0] hi_o
);
    localparam int W = XLEN + 2;

    always_comb begin
        lo_o = {cur_i, 2'b00};
        hi_o = {cur_i, 2'b11};
        AST_NA4_SPAN: assert (W'(hi_o - lo_o) == W'(3)); // R5
    end

endmodule

// File: rtl/rbd_napot_decode.sv
module rbd_napot_decode #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_i,
    output logic [XLEN+1:0] lo_o,
    output logic [XLEN+1:0] hi_o
);
    localparam int W = XLEN + 2;

    logic [W-1:0] seed;
    logic [W-1:0] seed_inc;
    logic [W-1:0] span;

    always_comb begin
        seed     = {cur_i, 2'b11};
        seed_inc = seed + W'(1);
        lo_o     = seed & seed_inc;
        hi_o     = seed | seed_inc;
        span     = hi_o ^ lo_o;
        AST_NAPOT_ALIGNED: assert (((span & (span + W'(1))) == '0) && ((lo_o & span) == '0)); // R6
        AST_NAPOT_MIN8: assert (span[2:0] == 3'b111); // R6
    end

endmodule

// File: rtl/region_bounds_decoder.sv
module region_bounds_decoder #(
    parameter int XLEN      = 32,
    parameter int ENTRY_IDX = 0
) (
    input  logic [1:0]      mode_i,
    input  logic [XLEN-1:0] addr_cur_i,
    input  logic [XLEN-1:0] addr_prev_i,
    output logic [XLEN+1:0] start_o,
    output logic [XLEN+1:0] end_o
);
    import rbd_pkg::*;

    localparam int W        = XLEN + 2;
    localparam bit IS_FIRST = (ENTRY_IDX == 0);

    typedef struct packed {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
    } bounds_t;

    logic [XLEN-1:0] prev_eff;
    logic [W-1:0]    tor_lo, tor_hi;
    logic [W-1:0]    na4_lo, na4_hi;
    logic [W-1:0]    pot_lo, pot_hi;
    region_mode_e    mode;
    bounds_t         bounds_d;

    generate
        if (IS_FIRST) begin : g_first
            logic unused_prev;
            assign unused_prev = ^addr_prev_i;
            assign prev_eff    = '0;
        end else begin : g_chain
            assign prev_eff = addr_prev_i;
        end
    endgenerate

    rbd_tor_decode #(.XLEN(XLEN)) u_tor (
        .prev_i (prev_eff),
        .cur_i  (addr_cur_i),
        .lo_o   (tor_lo),
        .hi_o   (tor_hi)
    );

    rbd_na4_decode #(.XLEN(XLEN)) u_na4 (
        .cur_i (addr_cur_i),
        .lo_o  (na4_lo),
        .hi_o  (na4_hi)
    );

    rbd_napot_decode #(.XLEN(XLEN)) u_napot (
        .cur_i (addr_cur_i),
        .lo_o  (pot_lo),
        .hi_o  (pot_hi)
    );

    always_comb begin
        mode = region_mode_e'(mode_i);
        unique case (mode)
            RGN_OFF:   bounds_d = '{lo: '0,     hi: '1};
            RGN_TOR:   bounds_d = '{lo: tor_lo, hi: tor_hi};
            RGN_NA4:   bounds_d = '{lo: na4_lo, hi: na4_hi};
            default:   bounds_d = '{lo: pot_lo, hi: pot_hi};
        endcase
        start_o = bounds_d.lo;
        end_o   = bounds_d.hi;
        if (IS_FIRST && mode == RGN_TOR) begin
            AST_FIRST_ZERO_BASE: assert (start_o == '0); // R4
        end
    end

endmodule

// File: tb/tb_region_bounds_decoder.sv
module tb_region_bounds_decoder;

    localparam int XA = 32;
    localparam int WA = XA + 2;
    localparam int XB = 8;
    localparam int WB = XB + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]    mode_a = '0;
    logic [XA-1:0] cur_a = '0, prev_a = '0;
    logic [WA-1:0] start_a, end_a;

    logic [1:0]    mode_b = '0;
    logic [XB-1:0] cur_b = '0, prev_b = '0;
    logic [WB-1:0] start_b, end_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    region_bounds_decoder #(.XLEN(XA), .ENTRY_IDX(3)) dut (
        .mode_i(mode_a), .addr_cur_i(cur_a), .addr_prev_i(prev_a),
        .start_o(start_a), .end_o(end_a)
    );

    region_bounds_decoder #(.XLEN(XB), .ENTRY_IDX(0)) dut_first (
        .mode_i(mode_b), .addr_cur_i(cur_b), .addr_prev_i(prev_b),
        .start_o(start_b), .end_o(end_b)
    );

    task automatic check_a(input string req, input logic [WA-1:0] es, input logic [WA-1:0] ee);
        checks++;
        if (start_a !== es || end_a !== ee) begin
            failures++;
            $display("FAIL %s: start=%h end=%h expected start=%h end=%h", req, start_a, end_a, es, ee);
        end
    endtask

    task automatic check_b(input string req, input logic [WB-1:0] es, input logic [WB-1:0] ee);
        checks++;
        if (start_b !== es || end_b !== ee) begin
            failures++;
            $display("FAIL %s: start=%h end=%h expected start=%h end=%h", req, start_b, end_b, es, ee);
        end
    endtask

    task automatic drive_a(input logic [1:0] m, input logic [XA-1:0] c, input logic [XA-1:0] p);
        @(posedge clk);
        #1;
        mode_a = m; cur_a = c; prev_a = p;
        #2;
    endtask

    task automatic drive_b(input logic [1:0] m, input logic [XB-1:0] c, input logic [XB-1:0] p);
        @(posedge clk);
        #1;
        mode_b = m; cur_b = c; prev_b = p;
        #2;
    endtask

    task automatic test_off();
        drive_a(2'd0, 32'h0000_1234, 32'hDEAD_BEEF);
        check_a("R1 off window", '0, '1);
        drive_b(2'd0, 8'hA5, 8'h5A);
        check_b("R1 off window narrow", '0, '1);
    endtask

    task automatic test_tor();
        drive_a(2'd1, 32'h0000_0200, 32'h0000_0100);
        check_a("R2 tor normal", 34'h400, 34'h7FF);
        drive_a(2'd1, 32'h8000_0000, 32'h0000_0001);
        check_a("R2 tor wide", 34'h4, 34'h1_FFFF_FFFF);
        drive_a(2'd1, 32'h0000_0200, 32'h0000_0300);
        check_a("R3 tor inverted", '0, '0);
        drive_a(2'd1, 32'h0000_0050, 32'h0000_0050);
        check_a("R3 tor equal regs", '0, '0);
        drive_a(2'd1, 32'h0000_0000, 32'h0000_0010);
        check_a("R8 tor zero wrap", 34'h40, '1);
    endtask

    task automatic test_first_entry();
        drive_b(2'd1, 8'h10, 8'hFF);
        check_b("R4 first entry ignores prev", '0, 10'h03F);
        drive_b(2'd1, 8'h10, 8'h00);
        check_b("R4 first entry prev zero", '0, 10'h03F);
        drive_b(2'd2, 8'h20, 8'hFF);
        check_b("R5 na4 first entry", 10'h080, 10'h083);
        drive_b(2'd3, 8'hFF, 8'h01);
        check_b("R7 napot full space narrow", '0, '1);
    endtask

    task automatic test_na4();
        drive_a(2'd2, 32'h0000_1000, 32'h0);
        check_a("R5 na4 low", 34'h4000, 34'h4003);
        drive_a(2'd2, 32'hFFFF_FFFF, 32'h0);
        check_a("R5 na4 top", 34'h3_FFFF_FFFC, 34'h3_FFFF_FFFF);
    endtask

    task automatic test_napot();
        logic [WA-1:0] base;
        base = 34'h1_0000_0000;
        for (int k = 0; k < 6; k++) begin
            logic [XA-1:0] reg_val;
            logic [WA-1:0] size;
            reg_val = XA'(base >> 2) | XA'((1 << k) - 1);
            size = WA'(8) << k;
            drive_a(2'd3, reg_val, 32'h0);
            check_a($sformatf("R6 napot k=%0d", k), base, base + size - WA'(1));
        end
        drive_a(2'd3, 32'hBFFF_FFFF, 32'h0);
        check_a("R6 napot half space", 34'h2_0000_0000, 34'h3_FFFF_FFFF);
        drive_a(2'd3, 32'hFFFF_FFFF, 32'h0);
        check_a("R7 napot full space", '0, '1);
    endtask

    task automatic test_comb_response();
        @(posedge clk);
        #1;
        mode_a = 2'd2; cur_a = 32'h0000_0003;
        #1;
        check_a("R9 same-cycle response", 34'hC, 34'hF);
        cur_a = 32'h0000_0004;
        #1;
        check_a("R9 follows input change", 34'h10, 34'h13);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #3;
        check_a("R1 reset-state outputs", '0, '1);
        test_off();
        test_tor();
        test_first_entry();
        test_na4();
        test_napot();
        test_comb_response();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule